// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

This block sits at the output of the last radix-4 decimation-in-frequency stage of a 1024-point streaming transform. That stage emits its results in base-4 digit-reversed order. The buffer puts them back into natural order k = 0 .. N-1. Each sample is a complex word: a 16-bit real part and a 16-bit imaginary part, so 32 bits are stored per sample.

Two banks of 1024 words take turns. While one bank is filled in arrival order, the other is read out at digit-reversed addresses. This lets frames run back to back with no idle cycles between them. A start flag on the input marks sample 0 of each frame. The output carries a valid flag that stays high for the whole frame and a start flag on its first sample.

Top module: `radix4_reorder`

## Requirements
- R1: While reset is asserted, and in the cycle that follows it, `out_vld`, `out_sof`, `out_re` and `out_im` are all zero.
- R2: The sample accepted at arrival position j of a frame (j counted from 0 at the sample carrying `in_sof`) comes out at output position rev(j). rev reverses the order of the five 2-bit digits of the 10-bit index: bits [1:0] swap with [9:8], bits [3:2] swap with [7:6], and bits [5:4] stay in place.
- R3: When a frame is supplied on consecutive cycles, `out_sof` is high in the cycle that begins 1024 clock edges after the edge that accepted input sample 0.
- R4: Frames supplied back to back with no gap produce output frames with no gap. `out_vld` stays high for 1024 x (number of frames) consecutive cycles, and every frame holds its own data.
- R5: `out_sof` is high only together with `out_vld`, and only on output sample 0 of each frame.
- R6: `out_vld` is high for exactly 1024 consecutive cycles per completed frame. It is low when no completed frame is waiting to be read.
- R7: A sample with `in_vld` high and `in_sof` low is dropped when no frame is open. No frame is open after reset until the first `in_sof`, and none is open after each completed frame until the next `in_sof`.
- R8: An `in_sof` that arrives part way through a frame restarts that frame at position 0. The partial frame never reaches the output.
- R9: Cycles with `in_vld` low inside a frame only stall the write side. The frame is still reordered correctly, and its output starts the cycle after the edge that accepted its last sample.
- R10: The 16-bit real and imaginary parts pass through unchanged and stay paired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample present this cycle |
| in_sof | input | 1 | Input sample is position 0 of a frame (qualified by in_vld) |
| in_re | input | 16 | Real part of input sample, two's complement |
| in_im | input | 16 | Imaginary part of input sample, two's complement |
| out_vld | output | 1 | Output sample present this cycle |
| out_sof | output | 1 | Output sample is k = 0 of a frame |
| out_re | output | 16 | Real part of output sample |
| out_im | output | 16 | Imaginary part of output sample |

## Verification
A wrong read address shows up within the first frame as a misplaced sample. The input data encodes both the frame tag and the arrival position, so the first wrong output position identifies the broken digit pair. A bank select that toggles at the wrong time, or a write counter that keeps counting past a frame boundary, shows up one frame later: either an output frame carries another frame's tag, or a frame appears that was never opened with a start flag. Errors in read-side framing show up at once on the output: a valid run whose length is not a multiple of 1024, or a start flag away from sample 0.

// File: rtl/radix4_reorder.sv
module radix4_reorder #(
  parameter int DIGITS = 5,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_sof,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_vld,
  output logic          out_sof,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);
  localparam int AW = 2 * DIGITS;
  localparam int N  = 1 << AW;
  localparam int WW = 2 * DW;
  localparam logic [AW:0] NFULL = (AW+1)'(N);

  function automatic logic [AW-1:0] rev4(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int i = 0; i < DIGITS; i++) r[2*i +: 2] = a[2*(DIGITS-1-i) +: 2];
    return r;
  endfunction

  logic [WW-1:0] mem [2][N];
  logic [AW-1:0] wr_cnt, wr_idx, rd_cnt;
  logic          armed, wbank, rd_bank, rd_act;
  logic          wr_en, done;

  assign wr_en  = in_vld & (in_sof | armed);
  assign wr_idx = in_sof ? '0 : wr_cnt;
  assign done   = wr_en & (wr_idx == '1);

  always_ff @(posedge clk)
    if (wr_en) mem[wbank][wr_idx] <= {in_re, in_im};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_cnt <= '0;
      armed  <= 1'b0;
      wbank  <= 1'b0;
    end else if (wr_en) begin
      wr_cnt <= wr_idx + 1'b1;
      armed  <= !done;
      if (done) wbank <= ~wbank;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act  <= 1'b0;
      rd_cnt  <= '0;
      rd_bank <= 1'b0;
      out_vld <= 1'b0;
      out_sof <= 1'b0;
      out_re  <= '0;
      out_im  <= '0;
    end else begin
      out_vld <= rd_act;
      out_sof <= rd_act && (rd_cnt == '0);
      if (rd_act) begin
        {out_re, out_im} <= mem[rd_bank][rev4(rd_cnt)];
        rd_cnt <= rd_cnt + 1'b1;
      end
      if (done) begin
        rd_act  <= 1'b1;
        rd_cnt  <= '0;
        rd_bank <= wbank;
      end else if (rd_act && rd_cnt == '1) begin
        rd_act <= 1'b0;
      end
    end

  logic [AW:0] ocnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ocnt <= '0;
    else if (out_vld) ocnt <= out_sof ? (AW+1)'(1) : ocnt + 1'b1;
    else              ocnt <= '0;

  // R5
  sof_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_vld);

  // R5
  sof_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (ocnt == '0 || ocnt == NFULL));

  // R6
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld) |-> ocnt == NFULL);

  // R4
  frame_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && ocnt == NFULL) |-> out_sof);

  // R4
  bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> rd_bank != wbank);
endmodule

// File: tb/sim_radix4_reorder.sv
module sim_radix4_reorder;
  localparam int CLK_P = 10;
  localparam int N = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 1'b0, in_sof = 1'b0;
  logic [15:0] in_re = '0, in_im = '0;
  logic out_vld, out_sof;
  logic [15:0] out_re, out_im;

  radix4_reorder u0 (.clk, .rst_n, .in_vld, .in_sof, .in_re, .in_im,
                     .out_vld, .out_sof, .out_re, .out_im);

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [9:0] rev(input logic [9:0] a);
    logic [9:0] r;
    for (int i = 0; i < 5; i++) r[2*i +: 2] = a[2*(4-i) +: 2];
    return r;
  endfunction

  function automatic logic [15:0] pat(input int tag, input int j);
    logic [5:0] t = tag[5:0];
    logic [9:0] p = j[9:0];
    return {t, p};
  endfunction

  // output monitor
  int tagq[$];
  int cur_tag = 0, ocount = 0, bad = 0, frames_done = 0;
  int run_len = 0, last_run = 0, vld_cycles = 0;
  bit in_frame = 1'b0;
  longint sof_cyc = 0, first_acc = 0, last_acc = 0;
  logic [31:0] bad_act, bad_exp;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) begin
        vld_cycles++;
        run_len++;
        if (out_sof) begin
          if (in_frame && ocount != N) chk(0, "R5", "sof inside frame at position", ocount, N);
          sof_cyc = cyc;
          if (tagq.size() == 0) begin
            chk(0, "R6", "frame with no opened input frame", 1, 0);
            cur_tag = -1;
          end else cur_tag = tagq.pop_front();
          in_frame = 1'b1; ocount = 0; bad = 0;
        end else if (!in_frame || ocount == N) begin
          chk(0, "R6", "valid outside a frame", ocount, N);
          in_frame = 1'b0;
        end
        if (in_frame && ocount < N) begin
          logic [15:0] er;
          er = pat(cur_tag, int'(rev(10'(ocount))));
          if ({out_re, out_im} !== {er, er ^ 16'hA5C3}) begin
            if (bad == 0) begin bad_act = {out_re, out_im}; bad_exp = {er, er ^ 16'hA5C3}; end
            bad++;
          end
          ocount++;
          if (ocount == N) begin
            chk(bad == 0, "R2 R10", "frame data (first wrong word)", bad_act, bad_exp);
            frames_done++;
          end
        end
      end else begin
        if (in_frame && ocount != N) chk(0, "R6", "frame truncated at", ocount, N);
        in_frame = 1'b0;
        if (run_len != 0) last_run = run_len;
        run_len = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_vld = 1'b0; in_sof = 1'b0; end
  endtask

  task automatic send(input int tag, input int j, input bit sof);
    @(negedge clk);
    in_vld = 1'b1; in_sof = sof;
    in_re = pat(tag, j); in_im = pat(tag, j) ^ 16'hA5C3;
    last_acc = cyc + 1;
  endtask

  task automatic feed(input int tag, input int gap);
    tagq.push_back(tag);
    for (int j = 0; j < N; j++) begin
      if (gap > 0 && (j % gap) == gap - 1) idle(1);
      send(tag, j, j == 0);
      if (j == 0) first_acc = last_acc;
    end
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames_done < target && t < 8000) begin @(negedge clk); t++; end
    chk(frames_done >= target, "R6", "frames delivered", frames_done, target);
    idle(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    chk(out_vld == 0 && out_sof == 0, "R1", "flags in reset", {out_vld, out_sof}, 0);
    chk({out_re, out_im} == 0, "R1", "data in reset", {out_re, out_im}, 0);
    rst_n = 1'b1;
    idle(1);
    chk({out_vld, out_sof, out_re, out_im} == 0, "R1", "after release", {out_re, out_im}, 0);
    for (int j = 0; j < N; j++) send(40, j, 1'b0);   // R7: no in_sof yet
    idle(40);
    chk(vld_cycles == 0, "R7", "output cycles from stray samples", vld_cycles, 0);
  endtask

  task automatic t_single();
    int fd = frames_done;
    feed(1, 0);
    idle(1);
    wait_frames(fd + 1);
    chk(sof_cyc == first_acc + N, "R3", "latency first sample to out_sof", sof_cyc - first_acc, N);
    chk(last_run == N, "R6", "valid run length", last_run, N);
    chk(out_vld == 0, "R6", "valid after frame", out_vld, 0);
  endtask

  task automatic t_back_to_back();
    int fd = frames_done;
    feed(2, 0);
    feed(3, 0);
    feed(4, 0);
    idle(1);
    wait_frames(fd + 3);
    chk(last_run == 3 * N, "R4", "continuous valid run", last_run, 3 * N);
    chk(frames_done == fd + 3, "R4", "frame count", frames_done, fd + 3);
  endtask

  task automatic t_drop_after_frame();
    int fd = frames_done;
    for (int j = 0; j < N; j++) send(61, j, 1'b0);   // R7: frame closed
    idle(N + 40);
    chk(frames_done == fd && out_vld == 0, "R7", "frames after stray samples", frames_done, fd);
    feed(5, 0);
    idle(1);
    wait_frames(fd + 1);
    chk(frames_done == fd + 1, "R7", "frame after strays", frames_done, fd + 1);
  endtask

  task automatic t_restart();
    int fd = frames_done;
    for (int j = 0; j < 300; j++) send(7, j, j == 0);  // partial, never queued
    feed(8, 0);
    idle(1);
    wait_frames(fd + 1);
    idle(N + 40);
    chk(frames_done == fd + 1, "R8", "frames after restart", frames_done, fd + 1);
    chk(tagq.size() == 0, "R8", "pending expected frames", tagq.size(), 0);
  endtask

  task automatic t_gaps();
    int fd = frames_done;
    feed(9, 3);
    idle(1);
    wait_frames(fd + 1);
    chk(sof_cyc == last_acc + 1, "R9", "out_sof after last accepted sample", sof_cyc - last_acc, 1);
    chk(last_run == N, "R9", "valid run with input gaps", last_run, N);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired at cycle", cyc, 150000);
    finish_run();
  end

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_drop_after_frame();
    t_restart();
    t_gaps();
    idle(5);
    finish_run();
  end
endmodule